// File: doc/BRIEF.md
# Interrupt Arbitration and Stack Sequencer

This block sits beside a small 8-bit CPU core. It decides which interrupt source is serviced next. It then drives the sequence of stack and vector-fetch addresses that the core's datapath follows. The block samples an active-low external interrupt line, a timer request and a software-interrupt request. Arbitration happens at each end-of-instruction strobe. While the core reports wait or stop, arbitration also runs on every idle cycle. The winning source receives a five-byte push of the machine state, with a register-select code that tells the datapath which register to place on the bus. The mask bit is then set, and the block issues the two vector byte addresses.

The block also owns a 6-bit stack pointer. That pointer lives in a fixed 64-byte page. The core uses it for two-byte subroutine pushes, for two-byte and five-byte return pops, and for a stack-pointer reload. The stack address presented to memory is the fixed page bits joined to the pointer. The block decodes no instructions and has no ALU. The core tells it when to call, return, reload the pointer, or set and clear the mask.

Top module: `isq_sequencer`

## Requirements
- R1: Each vector fetch is a pair of cycles with `vec_en_o` high. The first cycle issues the even address and the second issues the odd address. The even addresses are 0x1FFE (reset), 0x1FFC (software interrupt), 0x1FFA (external), 0x1FF8 (timer) and 0x1FF6 (timer taken while waiting).
- R2: At one arbitration point, a pending external request wins over the timer request, and the timer request wins over a software request.
- R3: A hardware request seen while `mask_o` is 1 stays pending and is serviced at the first arbitration point after the mask clears. A software request is taken whatever the mask is.
- R4: An interrupt entry starts the cycle after arbitration. It pushes five bytes in consecutive cycles, with `reg_sel_o` going 0,1,2,3,4 (0=PCL, 1=PCH, 2=X, 3=A, 4=CC) and the stack address falling by one each cycle. The even vector address follows in the next cycle.
- R5: `mask_o` becomes 1 in the cycle after the CC push. `busy_o` is high from the cycle after arbitration through the odd vector address cycle, and also during every stack sequence.
- R6: The stack address is 0x40 plus the 6-bit pointer. Reset and `rsp_i` set the pointer so that the next push writes 0x7F. A push below 0x40 wraps to 0x7F, and a pop above 0x7F wraps to 0x40.
- R7: `call_i` pushes two bytes (select 0, then 1). `rts_i` pops two bytes (select 1, then 0). `rti_i` pops five bytes (select 4 down to 0). Each pop first moves the pointer up by one.
- R8: A timer request taken while `wait_i` is 1 uses the 0x1FF6 vector. If the external and timer requests are both pending in wait, the external one goes first. A timer request taken later, outside wait, uses 0x1FF8.
- R9: While `stop_i` is 1, the timer request is ignored. An external request still leads to an interrupt entry.
- R10: A falling edge on `irq_n_i` sets the external request latch, and taking that request clears it. A line that stays low does not set the latch again until a return-from-interrupt pop ends while the line is still low.
- R11: Reset sets `mask_o`, clears the external request latch and resets the stack pointer. Right after reset, the block issues the reset vector pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eoi_i | input | 1 | End-of-instruction strobe; an arbitration point |
| irq_n_i | input | 1 | External interrupt line, active low |
| tmr_req_i | input | 1 | Timer interrupt request (already qualified by the timer's own mask) |
| swi_req_i | input | 1 | Software interrupt requested by the decoder |
| wait_i | input | 1 | Core is in wait; every idle cycle is an arbitration point |
| stop_i | input | 1 | Core is in stop; timer requests ignored |
| call_i | input | 1 | Push a two-byte return address |
| rts_i | input | 1 | Pop a two-byte return address |
| rti_i | input | 1 | Pop the five-byte machine state |
| rsp_i | input | 1 | Reload the stack pointer to the top of the page |
| mask_set_i | input | 1 | Set the interrupt mask |
| mask_clr_i | input | 1 | Clear the interrupt mask |
| stk_en_o | output | 1 | Stack access this cycle |
| stk_wr_o | output | 1 | 1 = push (write), 0 = pop (read) |
| stk_addr_o | output | 13 | Stack byte address |
| reg_sel_o | output | 3 | Register on the stack bus: 0 PCL, 1 PCH, 2 X, 3 A, 4 CC |
| vec_en_o | output | 1 | Vector byte fetch this cycle |
| vec_addr_o | output | 13 | Vector byte address |
| mask_o | output | 1 | Interrupt mask bit |
| busy_o | output | 1 | A sequence is in progress |

## Verification
The bench first applies simultaneous external, timer and software requests and checks the vector that wins. A wrong priority shows up as the wrong vector pair. Next, it leaves the interrupt line low across service and checks two things: the request must not fire again until a return-from-interrupt ends, and it must fire again once that return ends. A latch that follows the level instead of the edge would cause repeated entries, and one that ignores the return would miss wired sources. It runs 33 calls from a freshly reloaded pointer and a return straight after a reload. An adder that is not held to six bits would then leave the 0x40..0x7F page. Finally, it checks the wait-versus-normal timer vector and the stop-mode timer gating, where a design that latched the wait flag badly would fetch 0x1FF6 outside wait.

// File: rtl/isq_pkg.sv
// Shared types for the interrupt arbitration and stack sequencer.
// Assumes a single clock domain; encodings are internal only.
package isq_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PUSH = 3'd1,
        ST_POP  = 3'd2,
        ST_VHI  = 3'd3,
        ST_VLO  = 3'd4
    } isq_state_e;

    // Register-select codes seen on reg_sel_o
    localparam logic [2:0] SEL_PCL = 3'd0;
    localparam logic [2:0] SEL_PCH = 3'd1;
    localparam logic [2:0] SEL_CC  = 3'd4;

endpackage

// File: rtl/isq_ext_latch.sv
// External request latch.
// Sets on a falling edge of the active-low line, or when a return-from-
// interrupt ends while the line is still low; clears when the request is taken.
// Assumes irq_n_i is already synchronous to clk.
module isq_ext_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n_i,
    input  logic take_i,
    input  logic rearm_i,
    output logic pend_o
);
    logic irq_q;
    logic fall;

    // Previous line level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b1;
        else        irq_q <= irq_n_i;
    end

    assign fall = irq_q & ~irq_n_i;

    // Pending request; a new set wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)                              pend_o <= 1'b0;
        else if (fall || (rearm_i && !irq_n_i))  pend_o <= 1'b1;
        else if (take_i)                         pend_o <= 1'b0;
    end
endmodule

// File: rtl/isq_arbiter.sv
// Combinational arbiter: picks external, then timer, then software request.
// Also chooses the vector base, including the separate timer-from-wait vector.
// Assumes sample_i is high only in an idle cycle that is an arbitration point.
module isq_arbiter #(
    parameter int ADDR_W = 13,
    parameter logic [ADDR_W-1:0] VEC_SWI   = 'h1FFC,
    parameter logic [ADDR_W-1:0] VEC_EXT   = 'h1FFA,
    parameter logic [ADDR_W-1:0] VEC_TMR   = 'h1FF8,
    parameter logic [ADDR_W-1:0] VEC_TWAIT = 'h1FF6
) (
    input  logic              sample_i,
    input  logic              eoi_i,
    input  logic              mask_i,
    input  logic              wait_i,
    input  logic              stop_i,
    input  logic              ext_pend_i,
    input  logic              tmr_req_i,
    input  logic              swi_req_i,
    output logic              take_ext_o,
    output logic              take_any_o,
    output logic [ADDR_W-1:0] vec_o
);
    logic ext_ok, tmr_ok, swi_ok;
    logic take_tmr, take_swi;

    // Qualify each source against the mask and the low-power state
    always_comb begin
        ext_ok = ext_pend_i & ~mask_i;
        tmr_ok = tmr_req_i & ~mask_i & ~stop_i;
        swi_ok = swi_req_i & eoi_i;
    end

    // Fixed priority pick
    always_comb begin
        take_ext_o = sample_i & ext_ok;
        take_tmr   = sample_i & ~ext_ok & tmr_ok;
        take_swi   = sample_i & ~ext_ok & ~tmr_ok & swi_ok;
        take_any_o = take_ext_o | take_tmr | take_swi;
    end

    // Vector base for the winner
    always_comb begin
        if (ext_ok)      vec_o = VEC_EXT;
        else if (tmr_ok) vec_o = wait_i ? VEC_TWAIT : VEC_TMR;
        else             vec_o = VEC_SWI;
    end
endmodule

// File: rtl/isq_stack_ptr.sv
// Stack pointer with fixed page bits.
// A push uses the current pointer and then decrements it. A pop increments
// the pointer and uses the new value. The pointer wraps inside its own width.
module isq_stack_ptr #(
    parameter int ADDR_W = 13,
    parameter int SP_W   = 6,
    parameter int STK_PAGE = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reload_i,
    input  logic              push_i,
    input  logic              pop_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PAGE_W = ADDR_W - SP_W;
    localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(STK_PAGE);

    logic [SP_W-1:0] sp_q;
    logic [SP_W-1:0] sp_up;

    assign sp_up = sp_q + SP_W'(1);

    // Pointer update: reload to top, step down on push, step up on pop
    always_ff @(posedge clk) begin
        if (!rst_n || reload_i) sp_q <= '1;
        else if (push_i)        sp_q <= sp_q - SP_W'(1);
        else if (pop_i)         sp_q <= sp_up;
    end

    // Address presented this cycle
    assign addr_o = {PAGE, pop_i ? sp_up : sp_q};
endmodule

// File: rtl/isq_sequencer.sv
// Interrupt arbitration and stack sequencer (top).
// Arbitrates at end-of-instruction, or on every idle cycle in wait or stop.
// Then pushes the machine state, sets the mask and issues the vector pair.
// It also runs call pushes, return pops and pointer reloads on command.
// Assumes commands arrive only while busy_o is low; commands seen while busy,
// or in a cycle where an interrupt wins, are dropped.
module isq_sequencer #(
    parameter int ADDR_W   = 13,
    parameter int SP_W     = 6,
    parameter int STK_PAGE = 1,
    parameter logic [ADDR_W-1:0] VEC_RESET = 'h1FFE,
    parameter logic [ADDR_W-1:0] VEC_SWI   = 'h1FFC,
    parameter logic [ADDR_W-1:0] VEC_EXT   = 'h1FFA,
    parameter logic [ADDR_W-1:0] VEC_TMR   = 'h1FF8,
    parameter logic [ADDR_W-1:0] VEC_TWAIT = 'h1FF6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eoi_i,
    input  logic              irq_n_i,
    input  logic              tmr_req_i,
    input  logic              swi_req_i,
    input  logic              wait_i,
    input  logic              stop_i,
    input  logic              call_i,
    input  logic              rts_i,
    input  logic              rti_i,
    input  logic              rsp_i,
    input  logic              mask_set_i,
    input  logic              mask_clr_i,
    output logic              stk_en_o,
    output logic              stk_wr_o,
    output logic [ADDR_W-1:0] stk_addr_o,
    output logic [2:0]        reg_sel_o,
    output logic              vec_en_o,
    output logic [ADDR_W-1:0] vec_addr_o,
    output logic              mask_o,
    output logic              busy_o
);
    import isq_pkg::*;

    isq_state_e        state;
    logic [2:0]        step;
    logic [2:0]        last;
    logic              int_seq;
    logic              rti_seq;
    logic [ADDR_W-1:0] vbase;

    logic              idle;
    logic              sample;
    logic              ext_pend;
    logic              take_ext;
    logic              take_any;
    logic [ADDR_W-1:0] arb_vec;
    logic              go_call, go_rts, go_rti;
    logic              push_cyc, pop_cyc;
    logic              entry_done;
    logic              rearm;

    // Decode of the current cycle
    always_comb begin
        idle       = (state == ST_IDLE);
        sample     = idle & (eoi_i | wait_i | stop_i);
        go_call    = idle & ~take_any & call_i;
        go_rts     = idle & ~take_any & ~call_i & rts_i;
        go_rti     = idle & ~take_any & ~call_i & ~rts_i & rti_i;
        push_cyc   = (state == ST_PUSH);
        pop_cyc    = (state == ST_POP);
        entry_done = push_cyc & (step == last) & int_seq;
        rearm      = pop_cyc & (step == SEL_PCL) & rti_seq;
    end

    isq_ext_latch u_ext (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_n_i (irq_n_i),
        .take_i  (take_ext),
        .rearm_i (rearm),
        .pend_o  (ext_pend)
    );

    isq_arbiter #(
        .ADDR_W    (ADDR_W),
        .VEC_SWI   (VEC_SWI),
        .VEC_EXT   (VEC_EXT),
        .VEC_TMR   (VEC_TMR),
        .VEC_TWAIT (VEC_TWAIT)
    ) u_arb (
        .sample_i   (sample),
        .eoi_i      (eoi_i),
        .mask_i     (mask_o),
        .wait_i     (wait_i),
        .stop_i     (stop_i),
        .ext_pend_i (ext_pend),
        .tmr_req_i  (tmr_req_i),
        .swi_req_i  (swi_req_i),
        .take_ext_o (take_ext),
        .take_any_o (take_any),
        .vec_o      (arb_vec)
    );

    isq_stack_ptr #(
        .ADDR_W   (ADDR_W),
        .SP_W     (SP_W),
        .STK_PAGE (STK_PAGE)
    ) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload_i (idle & rsp_i),
        .push_i   (push_cyc),
        .pop_i    (pop_cyc),
        .addr_o   (stk_addr_o)
    );

    // Sequence state: arbitration, push and pop counting, vector pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_VHI;
            step    <= '0;
            last    <= '0;
            int_seq <= 1'b0;
            rti_seq <= 1'b0;
            vbase   <= VEC_RESET;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (take_any) begin
                        state   <= ST_PUSH;
                        step    <= SEL_PCL;
                        last    <= SEL_CC;
                        int_seq <= 1'b1;
                        vbase   <= arb_vec;
                    end else if (go_call) begin
                        state   <= ST_PUSH;
                        step    <= SEL_PCL;
                        last    <= SEL_PCH;
                        int_seq <= 1'b0;
                    end else if (go_rts) begin
                        state   <= ST_POP;
                        step    <= SEL_PCH;
                        rti_seq <= 1'b0;
                    end else if (go_rti) begin
                        state   <= ST_POP;
                        step    <= SEL_CC;
                        rti_seq <= 1'b1;
                    end
                end
                ST_PUSH: begin
                    if (step == last) state <= int_seq ? ST_VHI : ST_IDLE;
                    else              step  <= step + 3'd1;
                end
                ST_POP: begin
                    if (step == SEL_PCL) state <= ST_IDLE;
                    else                 step  <= step - 3'd1;
                end
                ST_VHI:  state <= ST_VLO;
                ST_VLO:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Mask bit: set by reset and by entry after the CC push, else by command
    always_ff @(posedge clk) begin
        if (!rst_n)          mask_o <= 1'b1;
        else if (entry_done) mask_o <= 1'b1;
        else if (mask_set_i) mask_o <= 1'b1;
        else if (mask_clr_i) mask_o <= 1'b0;
    end

    // Output decode
    always_comb begin
        stk_en_o   = push_cyc | pop_cyc;
        stk_wr_o   = push_cyc;
        reg_sel_o  = step;
        vec_en_o   = (state == ST_VHI) | (state == ST_VLO);
        vec_addr_o = (state == ST_VLO) ? {vbase[ADDR_W-1:1], 1'b1} : vbase;
        busy_o     = ~idle;
    end
endmodule

// File: rtl/isq_checker.sv
// Property checker for the sequencer, attached by bind.
// Observes only the top-level ports.
module isq_checker #(
    parameter int ADDR_W = 13,
    parameter int SP_W   = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stk_en_o,
    input logic              stk_wr_o,
    input logic [ADDR_W-1:0] stk_addr_o,
    input logic [2:0]        reg_sel_o,
    input logic              vec_en_o,
    input logic [ADDR_W-1:0] vec_addr_o,
    input logic              mask_o,
    input logic              busy_o
);
    AST_PUSH_DESCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_en_o && stk_wr_o && $past(stk_en_o && stk_wr_o))
        |-> stk_addr_o[SP_W-1:0] == $past(stk_addr_o[SP_W-1:0]) - SP_W'(1)); // R6
    AST_POP_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_en_o && !stk_wr_o && $past(stk_en_o && !stk_wr_o))
        |-> stk_addr_o[SP_W-1:0] == $past(stk_addr_o[SP_W-1:0]) + SP_W'(1)); // R7
    AST_MASK_AFTER_CC: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_en_o && stk_wr_o && reg_sel_o == 3'd4) |=> mask_o); // R5
    AST_CC_THEN_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (stk_en_o && stk_wr_o && reg_sel_o == 3'd4) |=> (vec_en_o && !vec_addr_o[0])); // R4
    AST_VECTOR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_en_o && !vec_addr_o[0])
        |=> (vec_en_o && vec_addr_o == $past(vec_addr_o) + ADDR_W'(1))); // R1
    AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_en_o || stk_en_o) |-> busy_o); // R5
endmodule

bind isq_sequencer isq_checker #(.ADDR_W(ADDR_W), .SP_W(SP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stk_en_o   (stk_en_o),
    .stk_wr_o   (stk_wr_o),
    .stk_addr_o (stk_addr_o),
    .reg_sel_o  (reg_sel_o),
    .vec_en_o   (vec_en_o),
    .vec_addr_o (vec_addr_o),
    .mask_o     (mask_o),
    .busy_o     (busy_o)
);

// File: tb/sim_isq_sequencer.sv
`timescale 1ns/1ps
module sim_isq_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic eoi_i = 0, irq_n_i = 1, tmr_req_i = 0, swi_req_i = 0, wait_i = 0, stop_i = 0;
    logic call_i = 0, rts_i = 0, rti_i = 0, rsp_i = 0, mask_set_i = 0, mask_clr_i = 0;
    logic        stk_en_o, stk_wr_o, vec_en_o, mask_o, busy_o;
    logic [12:0] stk_addr_o, vec_addr_o;
    logic [2:0]  reg_sel_o;

    always #5 clk = ~clk;

    isq_sequencer u0 (.*);

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [17:0] q[$];   // {kind[1:0], addr[12:0], sel[2:0]}; kind 1 push, 2 pop, 3 vector
    string       tq[$];
    logic [5:0]  sp_m = 6'h3F;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, expv);
        end
    endtask

    // Driver side of the scoreboard
    task automatic exp_item(input logic [1:0] k, input logic [12:0] a, input logic [2:0] s, input string tag);
        q.push_back({k, a, s});
        tq.push_back(tag);
    endtask
    task automatic exp_push(input logic [2:0] s, input string tag);
        exp_item(2'd1, {7'h01, sp_m}, s, tag);
        sp_m = sp_m - 6'd1;
    endtask
    task automatic exp_pop(input logic [2:0] s, input string tag);
        sp_m = sp_m + 6'd1;
        exp_item(2'd2, {7'h01, sp_m}, s, tag);
    endtask
    task automatic exp_int(input logic [12:0] v, input string tag);
        for (int s = 0; s < 5; s++) exp_push(3'(s), tag);
        exp_item(2'd3, v, 3'd0, tag);
        exp_item(2'd3, v | 13'd1, 3'd0, tag);
    endtask

    // Monitor side: compare every stack or vector cycle against the queue
    always @(negedge clk) begin
        if (rst_n && (stk_en_o || vec_en_o)) begin
            logic [17:0] got, e;
            string tag;
            got = {vec_en_o ? 2'd3 : (stk_wr_o ? 2'd1 : 2'd2),
                   vec_en_o ? vec_addr_o : stk_addr_o,
                   vec_en_o ? 3'd0 : reg_sel_o};
            if (q.size() == 0) chk(1'b0, "unexpected", int'(got), 0);
            else begin
                e = q.pop_front();
                tag = tq.pop_front();
                chk(got == e, tag, int'(got), int'(e));
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask
    task automatic settle();
        int guard = 0;
        @(negedge clk);
        while ((busy_o || q.size() != 0) && guard < 300) begin
            @(negedge clk); guard++;
        end
        tick();
    endtask
    task automatic do_eoi(input logic swi); eoi_i = 1; swi_req_i = swi; tick(); eoi_i = 0; swi_req_i = 0; endtask
    task automatic do_call(); call_i = 1; tick(); call_i = 0; endtask
    task automatic do_rts();  rts_i = 1;  tick(); rts_i = 0;  endtask
    task automatic do_rti();  rti_i = 1;  tick(); rti_i = 0;  endtask
    task automatic do_rsp();  rsp_i = 1;  tick(); rsp_i = 0; sp_m = 6'h3F; endtask
    task automatic do_mclr(); mask_clr_i = 1; tick(); mask_clr_i = 0; endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog act=running exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R11: reset vector pair right after reset, mask set
        exp_item(2'd3, 13'h1FFE, 3'd0, "R11 reset vector");
        exp_item(2'd3, 13'h1FFF, 3'd0, "R11 reset vector");
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(mask_o == 1'b1, "R11 mask after reset", mask_o, 1);
        chk(busy_o == 1'b1, "R5 busy during reset vector", busy_o, 1);
        tick();
        settle();

        // R6 R7: return right after reload wraps up to 0x40
        do_rsp();
        exp_pop(3'd1, "R6 pop wrap"); exp_pop(3'd0, "R7 rts order");
        do_rts(); settle();
        // R7: call pushes PCL then PCH from 0x7F, return pops them back
        do_rsp();
        exp_push(3'd0, "R7 call"); exp_push(3'd1, "R7 call");
        do_call(); settle();
        exp_pop(3'd1, "R7 rts"); exp_pop(3'd0, "R7 rts");
        do_rts(); settle();

        // R3 R10: edge while masked is held, then served after mask clears
        irq_n_i = 0; tick();
        do_eoi(0); tick(); irq_n_i = 1; tick(); tick();
        @(negedge clk);
        chk(busy_o == 1'b0 && q.size() == 0, "R3 masked request held", busy_o, 0);
        tick();
        do_mclr();
        exp_int(13'h1FFA, "R3 R4 held external entry");
        do_eoi(0);
        @(negedge clk);
        chk(busy_o == 1'b1, "R5 busy after arbitration", busy_o, 1);
        tick(); settle();
        chk(mask_o == 1'b1, "R5 mask after entry", mask_o, 1);
        for (int s = 4; s >= 0; s--) exp_pop(3'(s), "R7 rti order");
        do_rti(); settle();

        // R2: external beats timer beats software
        do_mclr();
        irq_n_i = 0; tick();
        tmr_req_i = 1;
        exp_int(13'h1FFA, "R2 external first");
        do_eoi(1); settle();
        do_mclr();
        exp_int(13'h1FF8, "R2 timer over software");  // R10: low line not retaken
        do_eoi(1); settle();
        tmr_req_i = 0;
        do_mclr();
        exp_int(13'h1FFC, "R2 software last");
        do_eoi(1); settle();
        exp_int(13'h1FFC, "R3 software ignores mask");
        do_eoi(1); settle();

        // R10: return with line still low rearms the request
        for (int s = 4; s >= 0; s--) exp_pop(3'(s), "R7 rti");
        do_rti(); settle();
        do_mclr();
        exp_int(13'h1FFA, "R10 rearm after return");
        do_eoi(0); settle();
        irq_n_i = 1; tick();
        for (int s = 4; s >= 0; s--) exp_pop(3'(s), "R7 rti");
        do_rti(); settle();

        // R8: timer from wait uses its own vector
        wait_i = 1; tmr_req_i = 1;
        exp_int(13'h1FF6, "R8 wait timer vector");
        do_mclr(); settle();
        // R8: external and timer together in wait, then timer normal
        irq_n_i = 0; tick();
        exp_int(13'h1FFA, "R8 external first in wait");
        do_mclr(); settle();
        wait_i = 0; irq_n_i = 1;
        do_mclr();
        exp_int(13'h1FF8, "R8 later timer normal vector");
        do_eoi(0); settle();
        tmr_req_i = 0;

        // R9: stop ignores timer, external still wakes
        stop_i = 1; tmr_req_i = 1;
        do_mclr();
        repeat (4) tick();
        @(negedge clk);
        chk(busy_o == 1'b0 && q.size() == 0, "R9 timer ignored in stop", busy_o, 0);
        tick();
        exp_int(13'h1FFA, "R9 external wakes stop");
        irq_n_i = 0; settle();
        stop_i = 0; tmr_req_i = 0; irq_n_i = 1; tick();

        // R6: 33 calls from reload wrap from 0x40 back to 0x7F
        do_rsp();
        for (int c = 0; c < 33; c++) begin
            exp_push(3'd0, "R6 push wrap"); exp_push(3'd1, "R6 push wrap");
            do_call(); settle();
        end

        @(negedge clk);
        chk(q.size() == 0, "R1 all expected items seen", q.size(), 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule